// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit with Opcode-Gated Overflow Trap

This block is the purely combinational execute-stage ALU of a 32-bit load-store integer core. It takes two register operands, a constant shift count, a 16-bit instruction immediate and a flag that swaps the immediate in for the second operand. It returns a 32-bit result, a zero flag and an overflow-trap request. Addition, subtraction, the four bitwise operations, signed and unsigned less-than tests, shifts by a constant or by a register count, and upper-immediate loads are all supported.

The second operand passes through an immediate extender first. Its rule follows the operation class. Arithmetic and compare operations widen the immediate with its sign bit. That includes the unsigned forms. Bitwise operations widen it with zeros. Whether a trap is raised depends only on which operation was requested. Only the signed add and signed subtract report two's-complement overflow. Their immediate forms report it too. The unsigned forms give the same sum and never trap. When a trap is raised, the result is still driven, and the pipeline around the block decides whether to suppress writeback.

The block holds no state and has no clock. The house style's state machine does not apply here. Its naming and layout are kept.

Top module: `int_alu`

## Requirements
- R1: Opcode ADD (0), ADDU (1), SUB (2) and SUBU (3) return a+b or a-b modulo 2^32, where b is the selected second operand.
- R2: ADD and SUB raise `ovf_trap_o` exactly when the two's-complement result overflows. This also applies when `imm_sel_i` is 1, which gives the add-immediate form.
- R3: `ovf_trap_o` stays 0 for every opcode other than ADD (0) and SUB (2), whatever the operand values.
- R4: With `imm_sel_i`=1, opcodes ADD, ADDU, SUB, SUBU, SLT (8) and SLTU (9) take bit 15 of the immediate and copy it into bits 31:16 of the second operand.
- R5: With `imm_sel_i`=1, opcodes AND (4), OR (5), XOR (6) and NOR (7) clear bits 31:16 of the second operand.
- R6: AND, OR, XOR and NOR return the bitwise a&b, a|b, a^b and ~(a|b).
- R7: SLT returns 1 when a<b in two's complement and SLTU returns 1 when a<b as natural numbers. Both return 0 otherwise, and bits 31:1 are always 0.
- R8: SLL (10), SRL (11) and SRA (12) shift operand a by `shamt_i`. SLL and SRL fill with zeros and SRA fills with bit 31 of a.
- R9: SLLV (13), SRLV (14) and SRAV (15) shift operand a by bits 4:0 of `opnd_b_i`. Bits 31:5 of that operand and `shamt_i` are ignored.
- R10: LUI (16) returns the immediate in bits 31:16 and zeros in bits 15:0, whatever the operands are.
- R11: `zero_o` is 1 exactly when `result_o` is all zeros.
- R12: While `ovf_trap_o` is 1, `result_o` still carries the wrapped sum or difference.
- R13: Opcodes 17 to 31 return 0 with no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code, encoded as listed in the requirements |
| opnd_a_i | input | 32 | First operand; the value that shifts act on |
| opnd_b_i | input | 32 | Second register operand; low 5 bits give the variable shift count |
| shamt_i | input | 5 | Constant shift count |
| imm_i | input | 16 | Instruction immediate |
| imm_sel_i | input | 1 | 1 replaces the second operand with the extended immediate |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | Result is all zeros |
| ovf_trap_o | output | 1 | Overflow-trap request |

## Verification
Two functions can meet in one evaluation: the overflow trap and the zero flag. A signed add of 0x80000000 to itself wraps to zero, so the trap and the zero flag must both be raised while the wrapped result stays visible. The same operand pair is then applied with ADDU. It must give the same zero result and zero flag with no trap. Both cases are judged at the ports, after the operands settle and away from the clock edge.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADDU = 5'd1,
        OP_SUB  = 5'd2,
        OP_SUBU = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_NOR  = 5'd7,
        OP_SLT  = 5'd8,
        OP_SLTU = 5'd9,
        OP_SLL  = 5'd10,
        OP_SRL  = 5'd11,
        OP_SRA  = 5'd12,
        OP_SLLV = 5'd13,
        OP_SRLV = 5'd14,
        OP_SRAV = 5'd15,
        OP_LUI  = 5'd16
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RLOG  = 2'd1,
        SH_RARI  = 2'd2
    } shift_kind_e;
endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              use_imm_i,
    input  logic              zero_ext_i,
    input  logic [DATA_W-1:0] reg_i,
    output logic [DATA_W-1:0] opnd_o
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic [PAD_W-1:0]  pad;
    logic [DATA_W-1:0] widened;

    // Zeros for bitwise forms, replicated sign bit for arithmetic forms.
    assign pad     = zero_ext_i ? '0 : {PAD_W{imm_i[IMM_W-1]}};
    assign widened = {pad, imm_i};
    assign opnd_o  = use_imm_i ? widened : reg_i;
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              ovf_o,
    output logic              lt_signed_o,
    output logic              lt_unsigned_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_x;
    logic [DATA_W:0]   wide;

    // Subtraction as a + ~b + 1; carry out of 1 means no borrow.
    assign b_x   = sub_i ? ~b_i : b_i;
    assign wide  = {1'b0, a_i} + {1'b0, b_x} + {{DATA_W{1'b0}}, sub_i};
    assign sum_o = wide[DATA_W-1:0];

    assign ovf_o         = (a_i[MSB] == b_x[MSB]) && (sum_o[MSB] != a_i[MSB]);
    assign lt_signed_o   = sum_o[MSB] ^ ovf_o;
    assign lt_unsigned_o = ~wide[DATA_W];
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import int_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]         val_i,
    input  logic [$clog2(DATA_W)-1:0] amt_i,
    input  shift_kind_e               kind_i,
    output logic [DATA_W-1:0]         out_o
);
    localparam int SH_W = $clog2(DATA_W);

    logic              fill;
    logic              left;
    logic [DATA_W-1:0] stg [SH_W+1];

    assign fill   = (kind_i == SH_RARI) ? val_i[DATA_W-1] : 1'b0;
    assign left   = (kind_i == SH_LEFT);
    assign stg[0] = val_i;

    // Logarithmic barrel: stage s moves the word by 2^s places.
    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        localparam int D = 1 << s;
        assign stg[s+1] = !amt_i[s] ? stg[s] :
                          left      ? {stg[s][DATA_W-D-1:0], {D{1'b0}}} :
                                      {{D{fill}}, stg[s][DATA_W-1:D]};
    end

    assign out_o = stg[SH_W];
endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [4:0]                op_i,
    input  logic [DATA_W-1:0]         opnd_a_i,
    input  logic [DATA_W-1:0]         opnd_b_i,
    input  logic [$clog2(DATA_W)-1:0] shamt_i,
    input  logic [IMM_W-1:0]          imm_i,
    input  logic                      imm_sel_i,
    output logic [DATA_W-1:0]         result_o,
    output logic                      zero_o,
    output logic                      ovf_trap_o
);
    localparam int SH_W  = $clog2(DATA_W);
    localparam int LOW_W = DATA_W - IMM_W;

    alu_op_e           op;
    logic              bitwise_op;
    logic              sub_op;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] sum;
    logic              ovf_raw;
    logic              lt_s;
    logic              lt_u;
    shift_kind_e       sh_kind;
    logic [SH_W-1:0]   sh_amt;
    logic [DATA_W-1:0] sh_out;

    assign op = alu_op_e'(op_i);

    always_comb begin
        bitwise_op = 1'b0;
        sub_op     = 1'b0;
        sh_kind    = SH_LEFT;
        sh_amt     = shamt_i;
        unique case (op)
            OP_AND, OP_OR, OP_XOR, OP_NOR:     bitwise_op = 1'b1;
            OP_SUB, OP_SUBU, OP_SLT, OP_SLTU:  sub_op = 1'b1;
            OP_SRL:  sh_kind = SH_RLOG;
            OP_SRA:  sh_kind = SH_RARI;
            OP_SLLV: sh_amt  = opnd_b_i[SH_W-1:0];
            OP_SRLV: begin sh_kind = SH_RLOG; sh_amt = opnd_b_i[SH_W-1:0]; end
            OP_SRAV: begin sh_kind = SH_RARI; sh_amt = opnd_b_i[SH_W-1:0]; end
            default: ;
        endcase
    end

    alu_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
        .imm_i      (imm_i),
        .use_imm_i  (imm_sel_i),
        .zero_ext_i (bitwise_op),
        .reg_i      (opnd_b_i),
        .opnd_o     (b_eff)
    );

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a_i           (opnd_a_i),
        .b_i           (b_eff),
        .sub_i         (sub_op),
        .sum_o         (sum),
        .ovf_o         (ovf_raw),
        .lt_signed_o   (lt_s),
        .lt_unsigned_o (lt_u)
    );

    alu_shifter #(.DATA_W(DATA_W)) u_shift (
        .val_i  (opnd_a_i),
        .amt_i  (sh_amt),
        .kind_i (sh_kind),
        .out_o  (sh_out)
    );

    always_comb begin
        result_o   = '0;
        ovf_trap_o = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                result_o   = sum;
                ovf_trap_o = ovf_raw;
            end
            OP_ADDU, OP_SUBU: result_o = sum;
            OP_AND:  result_o = opnd_a_i & b_eff;
            OP_OR:   result_o = opnd_a_i | b_eff;
            OP_XOR:  result_o = opnd_a_i ^ b_eff;
            OP_NOR:  result_o = ~(opnd_a_i | b_eff);
            OP_SLT:  result_o = {{(DATA_W-1){1'b0}}, lt_s};
            OP_SLTU: result_o = {{(DATA_W-1){1'b0}}, lt_u};
            OP_SLL, OP_SRL, OP_SRA,
            OP_SLLV, OP_SRLV, OP_SRAV: result_o = sh_out;
            OP_LUI:  result_o = {imm_i, {LOW_W{1'b0}}};
            default: ;
        endcase
    end

    assign zero_o = (result_o == '0);
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
    import int_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input logic [4:0]        op_i,
    input logic [DATA_W-1:0] opnd_a_i,
    input logic [DATA_W-1:0] opnd_b_i,
    input logic [IMM_W-1:0]  imm_i,
    input logic              imm_sel_i,
    input logic [DATA_W-1:0] result_o,
    input logic              zero_o,
    input logic              ovf_trap_o
);
    localparam int LOW_W = DATA_W - IMM_W;

    logic known;
    assign known = !$isunknown({op_i, opnd_a_i, opnd_b_i, imm_i, imm_sel_i,
                                result_o, zero_o, ovf_trap_o});

    always_comb begin
        if (known) begin
            // R3: only the signed add and subtract may request a trap
            a_r3_no_overflow: assert (!ovf_trap_o ||
                op_i == OP_ADD || op_i == OP_SUB);
            // R11: zero flag agrees with the result
            a_r11_zero_flag: assert (zero_o == (result_o == '0));
            // R10: upper-immediate layout
            a_r10_lui_layout: assert (op_i != OP_LUI ||
                (result_o[DATA_W-1:LOW_W] == imm_i && result_o[LOW_W-1:0] == '0));
            // R7: set-less-than yields a single bit
            a_r7_flag_width: assert (!(op_i == OP_SLT || op_i == OP_SLTU) ||
                result_o[DATA_W-1:1] == '0);
            // R12: register-form signed add keeps the wrapped sum when trapping
            a_r12_result_kept: assert (!(op_i == OP_ADD && !imm_sel_i && ovf_trap_o) ||
                result_o == opnd_a_i + opnd_b_i);
            // R2: a trapping register add has operands of equal sign
            a_r2_trap_signs: assert (!(op_i == OP_ADD && !imm_sel_i && ovf_trap_o) ||
                (opnd_a_i[DATA_W-1] == opnd_b_i[DATA_W-1] &&
                 result_o[DATA_W-1] != opnd_a_i[DATA_W-1]));
            // R13: codes past the last operation are inert
            a_r13_unused_code: assert (op_i <= OP_LUI ||
                (result_o == '0 && !ovf_trap_o));
        end
    end
endmodule

bind int_alu int_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
    .op_i       (op_i),
    .opnd_a_i   (opnd_a_i),
    .opnd_b_i   (opnd_b_i),
    .imm_i      (imm_i),
    .imm_sel_i  (imm_sel_i),
    .result_o   (result_o),
    .zero_o     (zero_o),
    .ovf_trap_o (ovf_trap_o)
);

// File: tb/int_alu_test.sv
module int_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op = 5'd0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [4:0]  shamt = '0;
    logic [15:0] imm = '0;
    logic        isel = 1'b0;
    logic [31:0] res;
    logic        zf;
    logic        trap;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    int_alu uut (
        .op_i(op), .opnd_a_i(a), .opnd_b_i(b), .shamt_i(shamt),
        .imm_i(imm), .imm_sel_i(isel),
        .result_o(res), .zero_o(zf), .ovf_trap_o(trap)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Apply on a falling edge, sample on the following rising half later.
    task automatic apply(input logic [4:0] o, input logic [31:0] xa, input logic [31:0] xb,
                         input logic [4:0] sh, input logic [15:0] im, input logic s);
        @(negedge clk);
        op = o; a = xa; b = xb; shamt = sh; imm = im; isel = s;
        #2;
    endtask

    task automatic t_reset_state;
        apply(5'd0, 32'h0, 32'h0, 5'd0, 16'h0, 1'b0);
        chk("R11 idle result", res, 32'h0);
        chk("R11 idle zero", {31'b0, zf}, 32'h1);
        chk("R3 idle trap", {31'b0, trap}, 32'h0);
    endtask

    task automatic t_add_sub;
        apply(5'd0, 32'd5, 32'd7, 5'd0, 16'h0, 1'b0);
        chk("R1 add", res, 32'd12);
        chk("R11 nonzero", {31'b0, zf}, 32'h0);
        apply(5'd2, 32'd5, 32'd3, 5'd0, 16'h0, 1'b0);
        chk("R1 sub", res, 32'd2);
        chk("R2 sub no ovf", {31'b0, trap}, 32'h0);
        apply(5'd1, 32'hffffffff, 32'h1, 5'd0, 16'h0, 1'b0);
        chk("R1 addu wrap", res, 32'h0);
        chk("R11 addu zero", {31'b0, zf}, 32'h1);
    endtask

    task automatic t_signed_trap;
        apply(5'd0, 32'h7fffffff, 32'h1, 5'd0, 16'h0, 1'b0);
        chk("R2 add trap", {31'b0, trap}, 32'h1);
        chk("R12 add result", res, 32'h80000000);
        apply(5'd2, 32'h80000000, 32'h1, 5'd0, 16'h0, 1'b0);
        chk("R2 sub trap", {31'b0, trap}, 32'h1);
        chk("R12 sub result", res, 32'h7fffffff);
        apply(5'd0, 32'h7fffffff, 32'h0, 5'd0, 16'h0001, 1'b1);
        chk("R2 addi trap", {31'b0, trap}, 32'h1);
        // trap and zero together
        apply(5'd0, 32'h80000000, 32'h80000000, 5'd0, 16'h0, 1'b0);
        chk("R2 trap with zero", {31'b0, trap}, 32'h1);
        chk("R11 zero with trap", {31'b0, zf}, 32'h1);
        chk("R12 wrapped zero", res, 32'h0);
    endtask

    task automatic t_unsigned_no_trap;
        apply(5'd1, 32'h7fffffff, 32'h1, 5'd0, 16'h0, 1'b0);
        chk("R3 addu", {31'b0, trap}, 32'h0);
        apply(5'd3, 32'h80000000, 32'h1, 5'd0, 16'h0, 1'b0);
        chk("R3 subu", {31'b0, trap}, 32'h0);
        chk("R1 subu", res, 32'h7fffffff);
        apply(5'd1, 32'h7fffffff, 32'h0, 5'd0, 16'h0001, 1'b1);
        chk("R3 addiu", {31'b0, trap}, 32'h0);
        apply(5'd1, 32'h80000000, 32'h80000000, 5'd0, 16'h0, 1'b0);
        chk("R3 addu zero no trap", {31'b0, trap}, 32'h0);
        chk("R11 addu zero", {31'b0, zf}, 32'h1);
        apply(5'd10, 32'hffffffff, 32'h0, 5'd31, 16'h0, 1'b0);
        chk("R3 shift no trap", {31'b0, trap}, 32'h0);
    endtask

    task automatic t_sign_ext;
        apply(5'd1, 32'd16, 32'h0, 5'd0, 16'hffff, 1'b1);
        chk("R4 addiu sext", res, 32'd15);
        apply(5'd9, 32'd5, 32'h0, 5'd0, 16'hffff, 1'b1);
        chk("R4 sltiu sext", res, 32'd1);
        apply(5'd8, 32'd5, 32'h0, 5'd0, 16'hffff, 1'b1);
        chk("R4 slti sext", res, 32'd0);
    endtask

    task automatic t_zero_ext;
        apply(5'd5, 32'h0, 32'h12345678, 5'd0, 16'hffff, 1'b1);
        chk("R5 ori zext", res, 32'h0000ffff);
        apply(5'd4, 32'hffffffff, 32'h0, 5'd0, 16'h8000, 1'b1);
        chk("R5 andi zext", res, 32'h00008000);
        apply(5'd6, 32'hffff0000, 32'h0, 5'd0, 16'hffff, 1'b1);
        chk("R5 xori zext", res, 32'hffffffff);
    endtask

    task automatic t_logic;
        apply(5'd4, 32'hf0f0f0f0, 32'hff00ff00, 5'd0, 16'h0, 1'b0);
        chk("R6 and", res, 32'hf000f000);
        apply(5'd5, 32'hf0f0f0f0, 32'h0f000f00, 5'd0, 16'h0, 1'b0);
        chk("R6 or", res, 32'hfff0fff0);
        apply(5'd6, 32'haaaa5555, 32'hffff0000, 5'd0, 16'h0, 1'b0);
        chk("R6 xor", res, 32'h55555555);
        apply(5'd7, 32'h0, 32'h0, 5'd0, 16'h0, 1'b0);
        chk("R6 nor ones", res, 32'hffffffff);
        apply(5'd7, 32'hffff0000, 32'h0000ffff, 5'd0, 16'h0, 1'b0);
        chk("R6 nor zero", res, 32'h0);
    endtask

    task automatic t_compare;
        apply(5'd8, 32'hffffffff, 32'h1, 5'd0, 16'h0, 1'b0);
        chk("R7 slt neg", res, 32'd1);
        apply(5'd9, 32'hffffffff, 32'h1, 5'd0, 16'h0, 1'b0);
        chk("R7 sltu big", res, 32'd0);
        apply(5'd8, 32'd9, 32'd9, 5'd0, 16'h0, 1'b0);
        chk("R7 slt equal", res, 32'd0);
        apply(5'd8, 32'h7fffffff, 32'h80000000, 5'd0, 16'h0, 1'b0);
        chk("R7 slt extremes", res, 32'd0);
        apply(5'd9, 32'h7fffffff, 32'h80000000, 5'd0, 16'h0, 1'b0);
        chk("R7 sltu extremes", res, 32'd1);
    endtask

    task automatic t_const_shift;
        apply(5'd10, 32'h1, 32'h0, 5'd31, 16'h0, 1'b0);
        chk("R8 sll", res, 32'h80000000);
        apply(5'd11, 32'h80000000, 32'h0, 5'd4, 16'h0, 1'b0);
        chk("R8 srl", res, 32'h08000000);
        apply(5'd12, 32'h80000000, 32'h0, 5'd4, 16'h0, 1'b0);
        chk("R8 sra neg", res, 32'hf8000000);
        apply(5'd12, 32'h40000000, 32'h0, 5'd1, 16'h0, 1'b0);
        chk("R8 sra pos", res, 32'h20000000);
    endtask

    task automatic t_var_shift;
        apply(5'd13, 32'h1, 32'h00000024, 5'd7, 16'h0, 1'b0);
        chk("R9 sllv low bits", res, 32'h10);
        apply(5'd15, 32'h80000000, 32'hffffffe1, 5'd7, 16'h0, 1'b0);
        chk("R9 srav", res, 32'hc0000000);
        apply(5'd14, 32'h80000000, 32'h00000020, 5'd3, 16'h0, 1'b0);
        chk("R9 srlv zero count", res, 32'h80000000);
    endtask

    task automatic t_lui_unused;
        apply(5'd16, 32'hffffffff, 32'hffffffff, 5'd3, 16'habcd, 1'b0);
        chk("R10 lui", res, 32'habcd0000);
        apply(5'd31, 32'h7fffffff, 32'h1, 5'd0, 16'h1234, 1'b1);
        chk("R13 unused result", res, 32'h0);
        chk("R13 unused trap", {31'b0, trap}, 32'h0);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_add_sub();
        t_signed_trap();
        t_unsigned_no_trap();
        t_sign_ext();
        t_zero_ext();
        t_logic();
        t_compare();
        t_const_shift();
        t_var_shift();
        t_lui_unused();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule